// File: doc/BRIEF.md
# Halfband Hilbert Analytic-Signal Filter

This block turns a stream of real, signed samples into an in-phase/quadrature pair. The quadrature output is the input passed through a Hilbert transformer FIR. The in-phase output is the same input delayed to the filter's centre, so the two outputs form an analytic signal. The intended use is a front end running near 2 MHz, with a passband centred on a quarter of the sample rate, for example about 10 kHz to 990 kHz.

Two properties of the Hilbert impulse response reduce the hardware:

- **Zero taps are skipped.** Every tap an even distance from the centre is zero, including the centre itself. Only the odd offsets 1, 3, ..., 2M-1 have coefficients.
- **Mirrored samples are pre-subtracted.** The response is antisymmetric, so the sample at offset +k and the sample at offset -k are subtracted before multiplying.

As a result, M multipliers cover a delay line of 4M-1 samples. The coefficients are fixed at elaboration.

A sample is taken on every cycle with `in_valid` high. There is no back-pressure. Each accepted sample yields exactly one output word a fixed number of cycles later. The I and Q values of that word travel through the same pipeline registers, so they always describe the same input position.

Top module: `hilbert_iq_fir`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `out_i` and `out_q` are zero, and every delay-line position holds zero.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, three clock edges later. `out_valid` is never high at any other time.
- R3: The delay line moves only on cycles with `in_valid` high. Data presented while `in_valid` is low has no effect on any later output.
- R4: `out_i` equals the accepted sample that lies (N-1)/2 accepted samples before the newest one, where N = 4M-1.
- R5: The raw quadrature sum is S = sum over j = 0..M-1 of h_j·(d[C+k] − d[C−k]). Here k = 2j+1, C = (N-1)/2, and d[0] is the newest accepted sample. h_j is the signed field `COEFS[j*COEF_W +: COEF_W]`.
- R6: S is rounded by adding 2^(FRAC-1) and then taking the floor of the division by 2^FRAC. An exact half therefore rounds toward plus infinity.
- R7: The rounded value is clamped to the range [−2^(OUT_W-1), 2^(OUT_W-1)−1] before it drives `out_q`.
- R8: While `out_valid` is low, `out_i` and `out_q` keep their previous values.
- R9: For the first N-1 samples accepted after reset, the outputs are computed as if every earlier position of the delay line held zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DATA_W | Real input sample, two's complement |
| out_valid | output | 1 | Output word present this cycle |
| out_i | output | DATA_W | In-phase output: the input delayed to the centre tap |
| out_q | output | OUT_W | Quadrature output: the Hilbert-filtered value, rounded and saturated |

## Verification
The assertions assume that `in_valid` is low while reset is held. Under that assumption, an output word seen after reset can only come from a sample accepted after reset, and the three-edge latency check never reaches back across a reset. The bench drops `in_valid` together with every reset assertion and raises it only after release.

`in_data` is treated as fully arbitrary. The bench drives random garbage on idle cycles to show that such data is never absorbed.

The bench runs the following stimulus:

- An impulse at every possible input amplitude, each followed by enough zeros to flush the line.
- Full-scale steps, which force the saturation path.
- Randomly gapped random samples.

// File: rtl/hbh_pkg.sv
package hbh_pkg;

  // Delay-line length that spans odd offsets 1..2M-1 on both sides of the centre.
  function automatic int line_len(input int pairs);
    return 4 * pairs - 1;
  endfunction

  // Index of the centre position (zero-valued tap, feeds the in-phase path).
  function automatic int centre_idx(input int len);
    return (len - 1) / 2;
  endfunction

  // Distance from the centre of the j-th nonzero coefficient.
  function automatic int odd_offset(input int j);
    return 2 * j + 1;
  endfunction

  // Width of one pre-subtracted product.
  function automatic int prod_width(input int dw, input int cw);
    return dw + 1 + cw;
  endfunction

endpackage

// File: rtl/hbh_tap_line.sv
module hbh_tap_line #(
  parameter int DATA_W = 8,
  parameter int PAIRS  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [DATA_W-1:0]         din,
  output logic [PAIRS*DATA_W-1:0]   older_flat,
  output logic [PAIRS*DATA_W-1:0]   newer_flat,
  output logic [DATA_W-1:0]         centre
);
  localparam int N = hbh_pkg::line_len(PAIRS);
  localparam int C = hbh_pkg::centre_idx(N);

  logic [N-1:0][DATA_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (shift_en) begin
      line_q <= {line_q[N-2:0], din};
    end
  end

  assign centre = line_q[C];

  for (genvar j = 0; j < PAIRS; j++) begin : g_pick
    localparam int K = hbh_pkg::odd_offset(j);
    assign older_flat[j*DATA_W +: DATA_W] = line_q[C+K];
    assign newer_flat[j*DATA_W +: DATA_W] = line_q[C-K];
  end

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line_q));

  // R3
  line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> line_q[0] == $past(din));

endmodule

// File: rtl/hbh_pair_mult.sv
module hbh_pair_mult #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int PAIRS  = 3,
  parameter logic [PAIRS*COEF_W-1:0] COEFS = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          v_in,
  input  logic [PAIRS*DATA_W-1:0]       older_flat,
  input  logic [PAIRS*DATA_W-1:0]       newer_flat,
  input  logic [DATA_W-1:0]             centre_in,
  output logic                          v_out,
  output logic [DATA_W-1:0]             centre_out,
  output logic [PAIRS*hbh_pkg::prod_width(DATA_W, COEF_W)-1:0] prods_flat
);
  localparam int PROD_W = hbh_pkg::prod_width(DATA_W, COEF_W);

  // Pre-subtraction of mirrored samples, then one multiply per nonzero pair.
  function automatic logic signed [PROD_W-1:0] pair_product(
    input logic signed [DATA_W-1:0] older,
    input logic signed [DATA_W-1:0] newer,
    input logic signed [COEF_W-1:0] coef
  );
    logic signed [DATA_W:0] diff;
    diff = {older[DATA_W-1], older} - {newer[DATA_W-1], newer};
    return PROD_W'(diff) * PROD_W'(coef);
  endfunction

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    logic signed [PROD_W-1:0] prod_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= pair_product(older_flat[j*DATA_W +: DATA_W],
                                         newer_flat[j*DATA_W +: DATA_W],
                                         COEFS[j*COEF_W +: COEF_W]);
    end
    assign prods_flat[j*PROD_W +: PROD_W] = prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out      <= 1'b0;
      centre_out <= '0;
    end else begin
      v_out      <= v_in;
      centre_out <= centre_in;
    end
  end

endmodule

// File: rtl/hbh_sum_sat.sv
module hbh_sum_sat #(
  parameter int DATA_W = 8,
  parameter int PAIRS  = 3,
  parameter int PROD_W = 19,
  parameter int ACC_W  = 22,
  parameter int OUT_W  = 8,
  parameter int FRAC   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       v_in,
  input  logic [PAIRS*PROD_W-1:0]    prods_flat,
  input  logic [DATA_W-1:0]          centre_in,
  output logic                       v_out,
  output logic [DATA_W-1:0]          i_out,
  output logic [OUT_W-1:0]           q_out
);
  localparam logic signed [ACC_W-1:0] QMAX_A = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] QMIN_A = -QMAX_A - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] HALF_A = ACC_W'(64'sd1 <<< (FRAC-1));
  localparam logic signed [OUT_W-1:0] QMAX_O = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] QMIN_O = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] round_half_up(input logic signed [ACC_W-1:0] a);
    return (a + HALF_A) >>> FRAC;
  endfunction

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] r);
    if (r > QMAX_A)      return QMAX_O;
    else if (r < QMIN_A) return QMIN_O;
    else                 return r[OUT_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int j = 0; j < PAIRS; j++) begin
      acc = acc + {{(ACC_W-PROD_W){prods_flat[j*PROD_W+PROD_W-1]}}, prods_flat[j*PROD_W +: PROD_W]};
    end
  end

  logic signed [ACC_W-1:0] rounded;
  logic sat_hi, sat_lo;
  assign rounded = round_half_up(acc);
  assign sat_hi  = rounded > QMAX_A;
  assign sat_lo  = rounded < QMIN_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      i_out <= '0;
      q_out <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        i_out <= centre_in;
        q_out <= clamp(rounded);
      end
    end
  end

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_hi) |=> q_out == QMAX_O);

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_lo) |=> q_out == QMIN_O);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_out |-> ($stable(q_out) && $stable(i_out)) || $past(!rst_n));

endmodule

// File: rtl/hilbert_iq_fir.sv
module hilbert_iq_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int PAIRS  = 3,
  parameter int OUT_W  = 8,
  parameter int FRAC   = 8,
  parameter logic [PAIRS*COEF_W-1:0] COEFS = {10'sd33, 10'sd54, 10'sd163}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [OUT_W-1:0]  out_q
);
  localparam int PROD_W = hbh_pkg::prod_width(DATA_W, COEF_W);
  localparam int ACC_W  = PROD_W + $clog2(PAIRS) + 1;

  logic [PAIRS*DATA_W-1:0] older_flat, newer_flat;
  logic [DATA_W-1:0]       line_centre, mult_centre;
  logic [PAIRS*PROD_W-1:0] prods_flat;
  logic                    line_valid, mult_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_valid <= 1'b0;
    else        line_valid <= in_valid;
  end

  hbh_tap_line #(.DATA_W(DATA_W), .PAIRS(PAIRS)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_data),
    .older_flat(older_flat), .newer_flat(newer_flat), .centre(line_centre)
  );

  hbh_pair_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PAIRS(PAIRS), .COEFS(COEFS)) u_mult (
    .clk(clk), .rst_n(rst_n), .v_in(line_valid),
    .older_flat(older_flat), .newer_flat(newer_flat), .centre_in(line_centre),
    .v_out(mult_valid), .centre_out(mult_centre), .prods_flat(prods_flat)
  );

  hbh_sum_sat #(.DATA_W(DATA_W), .PAIRS(PAIRS), .PROD_W(PROD_W), .ACC_W(ACC_W),
                .OUT_W(OUT_W), .FRAC(FRAC)) u_sum (
    .clk(clk), .rst_n(rst_n), .v_in(mult_valid), .prods_flat(prods_flat),
    .centre_in(mult_centre), .v_out(out_valid), .i_out(out_i), .q_out(out_q)
  );

  // R2
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R2
  latency_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  // R4
  i_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_i == $past(line_centre, 2));

endmodule

// File: tb/test_hilbert_iq_fir.sv
module test_hilbert_iq_fir;
  localparam int DATA_W = 8;
  localparam int COEF_W = 10;
  localparam int PAIRS  = 3;
  localparam int OUT_W  = 8;
  localparam int FRAC   = 8;
  localparam int N      = 4 * PAIRS - 1;
  localparam int C      = (N - 1) / 2;
  localparam int H [PAIRS] = '{163, 54, 33};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic [DATA_W-1:0] out_i;
  logic [OUT_W-1:0] out_q;

  always #2 clk = ~clk;

  hilbert_iq_fir #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PAIRS(PAIRS), .OUT_W(OUT_W),
                   .FRAC(FRAC), .COEFS({10'sd33, 10'sd54, 10'sd163})) i_hilbert_iq_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  int hist [N];
  int accepted = 0;
  int exp_i [$];
  int exp_q [$];
  string tag_i [$];
  string tag_q [$];
  bit vp0 = 0, vp1 = 0, vp2 = 0;
  int last_i = 0, last_q = 0;
  bit gap_phase = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int floor_div(input int a, input int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  task automatic model_accept(input int x);
    int acc, r, q, lim_hi, lim_lo, md;
    string tq, ti;
    for (int p = N - 1; p > 0; p--) hist[p] = hist[p-1];
    hist[0] = x;
    accepted++;
    acc = 0;
    for (int j = 0; j < PAIRS; j++) acc += H[j] * (hist[C + 2*j + 1] - hist[C - 2*j - 1]);
    r = floor_div(acc + (1 << (FRAC - 1)), 1 << FRAC);
    lim_hi = (1 << (OUT_W - 1)) - 1;
    lim_lo = -(1 << (OUT_W - 1));
    q = (r > lim_hi) ? lim_hi : (r < lim_lo) ? lim_lo : r;
    md = ((acc % 256) + 256) % 256;
    if (q != r)               tq = "R7";
    else if (md == 128)       tq = "R6";
    else if (accepted < N)    tq = "R9";
    else if (gap_phase)       tq = "R3";
    else                      tq = "R5";
    ti = (accepted < N) ? "R9" : (gap_phase ? "R3" : "R4");
    exp_i.push_back(hist[C]);
    exp_q.push_back(q);
    tag_i.push_back(ti);
    tag_q.push_back(tq);
  endtask

  task automatic observe();
    int ai, aq;
    ai = int'($signed(out_i));
    aq = int'($signed(out_q));
    check(out_valid == vp2, "R2 out_valid timing", int'(out_valid), int'(vp2));
    if (out_valid && exp_q.size() > 0) begin
      int ei, eq;
      string ti, tq;
      ei = exp_i.pop_front(); eq = exp_q.pop_front();
      ti = tag_i.pop_front(); tq = tag_q.pop_front();
      check(ai == ei, {ti, " out_i"}, ai, ei);
      check(aq == eq, {tq, " out_q"}, aq, eq);
    end else if (!out_valid) begin
      check(ai == last_i && aq == last_q, "R8 hold while idle", aq, last_q);
    end
    last_i = ai;
    last_q = aq;
  endtask

  task automatic step(input bit v, input int d);
    @(negedge clk);
    observe();
    in_valid = v;
    in_data = DATA_W'(d);
    vp2 = vp1; vp1 = vp0; vp0 = v;
    if (v) model_accept(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < N; p++) hist[p] = 0;
    accepted = 0;
    exp_i.delete(); exp_q.delete(); tag_i.delete(); tag_q.delete();
    vp0 = 0; vp1 = 0; vp2 = 0;
    // R1: outputs cleared during and right after reset
    check(out_valid == 1'b0, "R1 out_valid reset", int'(out_valid), 0);
    check(out_i == '0, "R1 out_i reset", int'($signed(out_i)), 0);
    check(out_q == '0, "R1 out_q reset", int'($signed(out_q)), 0);
    last_i = 0;
    last_q = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9: first samples see a zero-filled line; R5/R6: impulse at every amplitude
    for (int a = -128; a < 128; a++) begin
      step(1, a);
      for (int z = 0; z < N; z++) step(1, 0);
    end
    // R7: full-scale steps drive both saturation limits
    for (int r = 0; r < 4; r++) begin
      for (int z = 0; z < N; z++) step(1, 127);
      for (int z = 0; z < N; z++) step(1, -128);
    end
    // R3: gapped stream with garbage on idle cycles
    gap_phase = 1;
    for (int t = 0; t < 3000; t++) begin
      bit v;
      v = ($urandom % 10) < 7;
      step(v, int'($urandom % 256) - 128);
    end
    gap_phase = 0;
    for (int t = 0; t < 6; t++) step(0, 0);
    // R1/R9: reset mid-run, then impulse into a cleared line
    do_reset();
    step(1, 100);
    for (int z = 0; z < N + 2; z++) step(1, 0);
    for (int t = 0; t < 1000; t++) step(1, int'($urandom % 256) - 128);
    for (int t = 0; t < 6; t++) step(0, 0);
    check(exp_q.size() == 0, "R2 all outputs delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule